// File: doc/BRIEF.md
# Speculative alias-check tracker

This block keeps two marks per line of a set-associative speculative L1 tag array: a monitor mark that software sets and clears on purpose, and a written mark that every store inside a hardware atomic region sets. A compiler that moves loads up or stores down past accesses that may alias wraps the moved code in a region. It puts a monitored load where the hoisted value is read, and a checked store where a possible alias has to be caught. When a check finds a mark set, the region is rolled back and execution restarts at the safe-version PC given when the region began.

The block accepts one command per cycle: an opcode, a byte address, and a PC that only region-begin uses. A line lookup with a tag match and LRU replacement decides hit, miss and victim way. Every output is registered and changes at the clock edge that samples the command. A remote-access input carries snoops from other agents. A snoop hitting a line with the written mark aborts the region. A snoop hitting a line that has only the monitor mark does not.

Top module: `spec_alias_tracker`

## Requirements
- R1: After reset no region is active, abort and commit are low, and no line is resident, so the first access to any address misses.
- R2: Begin (opcode 1) with no region active opens a region and latches cmd_pc as the safe PC. A begin issued while a region is active changes nothing, and the first PC stays latched.
- R3: End (opcode 2) in an active region gives a one-cycle commit pulse, closes the region and clears every mark, so a later region starts with no marks.
- R4: Abort (opcode 3) in an active region gives a one-cycle abort pulse, puts the latched safe PC on redirect_pc, closes the region and clears every mark.
- R5: A monitored load (opcode 5) sets the monitor mark of its line. An ordinary load (opcode 4) never sets it.
- R6: Clear-monitor (opcode 6) resets the monitor mark of a resident line. The line stays resident and keeps its written mark. On a miss it does nothing.
- R7: Every store in a region sets the written mark of its line. This covers the plain store (opcode 7) and all checked stores that complete.
- R8: A checked store aborts when its line hits with a certain mark set: variant R (opcode 8) on the monitor mark, variant W (opcode 9) on the written mark, variant RW (opcode 10) on either. Otherwise it completes as a store.
- R9: A checked store that misses does not abort. Its line is allocated with the written mark set.
- R10: In a region, a miss whose LRU victim is valid and carries either mark aborts the region. Evicting an unmarked line does not abort.
- R11: In a region, a snoop whose line hits with the written mark set aborts. A snoop that hits a line with only the monitor mark, or that misses, does not abort.
- R12: With no region active, end and abort produce no pulse, no command sets or checks a mark, and nothing aborts.
- R13: Bits [5:0] of an address are the line offset, [11:6] the set and [31:12] the tag. Each set holds 8 ways, the least recently used way is replaced, and hit_o reports the hit of the previous load, store or clear-monitor.
- R14: When an abort cause and an end fall in the same cycle, the abort wins: an abort pulse, no commit pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_op | input | 4 | Command opcode, 0 = no command |
| cmd_addr | input | 32 | Byte address of the command |
| cmd_pc | input | 32 | Safe-version PC, used by begin |
| snoop_valid | input | 1 | Remote access present this cycle |
| snoop_addr | input | 32 | Byte address of the remote access |
| abort_o | output | 1 | One-cycle region abort pulse |
| redirect_pc_o | output | 32 | Safe PC presented with the last abort |
| commit_o | output | 1 | One-cycle region commit pulse |
| hit_o | output | 1 | Previous access hit a resident line |
| region_active_o | output | 1 | A region is open |

## Verification
Commit and abort can fall in the same cycle when an end command arrives together with a snoop that hits a line carrying the written mark. The bench drives such an end and snoop in the same cycle after a plain store in the region. It expects an abort pulse, no commit pulse, the region closed and the latched safe PC on redirect. As a contrast, the same pairing on a line with only the monitor mark must give a clean commit.

// File: rtl/spec_alias_pkg.sv
package spec_alias_pkg;

    typedef enum logic [3:0] {
        OP_NOP       = 4'd0,
        OP_BEGIN     = 4'd1,
        OP_END       = 4'd2,
        OP_ABORT     = 4'd3,
        OP_LOAD      = 4'd4,
        OP_LOAD_MON  = 4'd5,
        OP_CLR_MON   = 4'd6,
        OP_STORE     = 4'd7,
        OP_ST_CHK_R  = 4'd8,
        OP_ST_CHK_W  = 4'd9,
        OP_ST_CHK_RW = 4'd10
    } sa_op_e;

endpackage

// File: rtl/sa_tag_lru.sv
module sa_tag_lru #(
    parameter int SETS  = 64,
    parameter int WAYS  = 8,
    parameter int TAG_W = 20,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] look_set,
    input  logic [TAG_W-1:0] look_tag,
    output logic             hit,
    output logic [WAY_W-1:0] hit_way,
    output logic [WAY_W-1:0] victim_way,
    output logic             victim_valid,
    input  logic [IDX_W-1:0] snp_set,
    input  logic [TAG_W-1:0] snp_tag,
    output logic             snp_hit,
    output logic [WAY_W-1:0] snp_way,
    input  logic             upd_en,
    input  logic             upd_alloc,
    input  logic [IDX_W-1:0] upd_set,
    input  logic [WAY_W-1:0] upd_way,
    input  logic [TAG_W-1:0] upd_tag
);

    logic [SETS-1:0][WAYS-1:0] valid_q, valid_d;
    logic [TAG_W-1:0]          tag_q [SETS][WAYS];
    logic [TAG_W-1:0]          tag_d [SETS][WAYS];
    logic [WAY_W-1:0]          age_q [SETS][WAYS];
    logic [WAY_W-1:0]          age_d [SETS][WAYS];

    logic [WAYS-1:0] match, snp_match;
    logic            any_free;

    // Lookup for the local command and for the snoop
    always_comb begin
        match     = '0;
        snp_match = '0;
        hit_way   = '0;
        snp_way   = '0;
        for (int w = 0; w < WAYS; w++) begin
            match[w]     = valid_q[look_set][w] && (tag_q[look_set][w] == look_tag);
            snp_match[w] = valid_q[snp_set][w] && (tag_q[snp_set][w] == snp_tag);
            if (match[w])     hit_way = WAY_W'(w);
            if (snp_match[w]) snp_way = WAY_W'(w);
        end
        hit     = |match;
        snp_hit = |snp_match;
    end

    // Victim: lowest free way, otherwise the oldest way
    always_comb begin
        victim_way = '0;
        any_free   = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (age_q[look_set][w] == WAY_W'(WAYS - 1)) victim_way = WAY_W'(w);
        end
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_q[look_set][w]) begin
                victim_way = WAY_W'(w);
                any_free   = 1'b1;
            end
        end
        victim_valid = !any_free;
    end

    // Next state: allocation and recency update
    always_comb begin
        valid_d = valid_q;
        tag_d   = tag_q;
        age_d   = age_q;
        if (upd_en) begin
            if (upd_alloc) begin
                valid_d[upd_set][upd_way] = 1'b1;
                tag_d[upd_set][upd_way]   = upd_tag;
            end
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == upd_way)
                    age_d[upd_set][w] = '0;
                else if (age_q[upd_set][w] < age_q[upd_set][upd_way])
                    age_d[upd_set][w] = age_q[upd_set][w] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    tag_q[s][w] <= '0;
                    age_q[s][w] <= WAY_W'(w);
                end
            end
        end else begin
            valid_q <= valid_d;
            tag_q   <= tag_d;
            age_q   <= age_d;
        end
    end

    AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match)) else $error("duplicate tag in set"); // R13

    AST_SNOOP_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(snp_match)) else $error("duplicate tag on snoop"); // R11

endmodule

// File: rtl/sa_mark_bits.sv
module sa_mark_bits #(
    parameter int SETS = 64,
    parameter int WAYS = 8,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             region_on,
    input  logic [IDX_W-1:0] rd_set,
    input  logic [WAY_W-1:0] rd_way,
    output logic             rd_sr,
    output logic             rd_sw,
    input  logic [IDX_W-1:0] snp_set,
    input  logic [WAY_W-1:0] snp_way,
    output logic             snp_sw,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_set,
    input  logic [WAY_W-1:0] wr_way,
    input  logic             wr_sr,
    input  logic             wr_sw,
    input  logic             flash_clr
);

    logic [SETS-1:0][WAYS-1:0] sr_q, sr_d;
    logic [SETS-1:0][WAYS-1:0] sw_q, sw_d;

    assign rd_sr  = sr_q[rd_set][rd_way];
    assign rd_sw  = sw_q[rd_set][rd_way];
    assign snp_sw = sw_q[snp_set][snp_way];

    always_comb begin
        sr_d = sr_q;
        sw_d = sw_q;
        if (wr_en) begin
            sr_d[wr_set][wr_way] = wr_sr;
            sw_d[wr_set][wr_way] = wr_sw;
        end
        if (flash_clr) begin
            sr_d = '0;
            sw_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
            sw_q <= '0;
        end else begin
            sr_q <= sr_d;
            sw_q <= sw_d;
        end
    end

    AST_FLASH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flash_clr |=> (sr_q == '0 && sw_q == '0)) else $error("marks left after flash clear"); // R3

    AST_IDLE_NO_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        !region_on |-> (sr_q == '0 && sw_q == '0)) else $error("mark present outside region"); // R12

endmodule

// File: rtl/spec_alias_tracker.sv
module spec_alias_tracker
    import spec_alias_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int PC_W       = 32,
    parameter int LINE_BYTES = 64,
    parameter int SETS       = 64,
    parameter int WAYS       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [PC_W-1:0]   cmd_pc,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              abort_o,
    output logic [PC_W-1:0]   redirect_pc_o,
    output logic              commit_o,
    output logic              hit_o,
    output logic              region_active_o
);

    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int IDX_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

    typedef struct packed {
        logic            active;
        logic [PC_W-1:0] safe_pc;
        logic [PC_W-1:0] redir;
        logic            abort;
        logic            commit;
        logic            hit;
    } ctl_t;

    ctl_t ctl_q, ctl_d;
    sa_op_e op;

    logic [IDX_W-1:0] cmd_set, snp_set;
    logic [TAG_W-1:0] cmd_tag, snp_tag;
    logic             hit, victim_valid, snp_hit;
    logic [WAY_W-1:0] hit_way, victim_way, snp_way, sel_way;
    logic             cur_sr, cur_sw, snp_sw;
    logic             is_access, is_clr, is_store, is_chk;
    logic             chk_fail, evict_fail, snoop_fail, do_abort, do_commit, do_begin;
    logic             upd_en, mark_wr, new_sr, new_sw, base_sr, base_sw;

    assign op      = sa_op_e'(cmd_op);
    assign cmd_set = cmd_addr[OFF_W +: IDX_W];
    assign cmd_tag = cmd_addr[ADDR_W-1 -: TAG_W];
    assign snp_set = snoop_addr[OFF_W +: IDX_W];
    assign snp_tag = snoop_addr[ADDR_W-1 -: TAG_W];
    assign sel_way = hit ? hit_way : victim_way;

    sa_tag_lru #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) i_tags (
        .clk          (clk),
        .rst_n        (rst_n),
        .look_set     (cmd_set),
        .look_tag     (cmd_tag),
        .hit          (hit),
        .hit_way      (hit_way),
        .victim_way   (victim_way),
        .victim_valid (victim_valid),
        .snp_set      (snp_set),
        .snp_tag      (snp_tag),
        .snp_hit      (snp_hit),
        .snp_way      (snp_way),
        .upd_en       (upd_en),
        .upd_alloc    (is_access && !hit),
        .upd_set      (cmd_set),
        .upd_way      (sel_way),
        .upd_tag      (cmd_tag)
    );

    sa_mark_bits #(.SETS(SETS), .WAYS(WAYS)) i_marks (
        .clk       (clk),
        .rst_n     (rst_n),
        .region_on (ctl_q.active),
        .rd_set    (cmd_set),
        .rd_way    (sel_way),
        .rd_sr     (cur_sr),
        .rd_sw     (cur_sw),
        .snp_set   (snp_set),
        .snp_way   (snp_way),
        .snp_sw    (snp_sw),
        .wr_en     (mark_wr),
        .wr_set    (cmd_set),
        .wr_way    (sel_way),
        .wr_sr     (new_sr),
        .wr_sw     (new_sw),
        .flash_clr (do_abort || do_commit)
    );

    // Command classification
    always_comb begin
        is_chk    = (op == OP_ST_CHK_R) || (op == OP_ST_CHK_W) || (op == OP_ST_CHK_RW);
        is_store  = (op == OP_STORE) || is_chk;
        is_access = (op == OP_LOAD) || (op == OP_LOAD_MON) || is_store;
        is_clr    = (op == OP_CLR_MON);
        upd_en    = is_access || (is_clr && hit);
    end

    // Mark update for the addressed line; a fresh allocation starts unmarked
    always_comb begin
        base_sr = hit && cur_sr;
        base_sw = hit && cur_sw;
        new_sr  = base_sr;
        new_sw  = base_sw;
        if (ctl_q.active) begin
            if (op == OP_LOAD_MON) new_sr = 1'b1;
            if (is_clr)            new_sr = 1'b0;
            if (is_store)          new_sw = 1'b1;
        end
        mark_wr = upd_en;
    end

    // Abort sources and region control
    always_comb begin
        chk_fail   = ctl_q.active && hit &&
                     (((op == OP_ST_CHK_R)  && cur_sr) ||
                      ((op == OP_ST_CHK_W)  && cur_sw) ||
                      ((op == OP_ST_CHK_RW) && (cur_sr || cur_sw)));
        evict_fail = ctl_q.active && is_access && !hit && victim_valid && (cur_sr || cur_sw);
        snoop_fail = ctl_q.active && snoop_valid && snp_hit && snp_sw;
        do_abort   = chk_fail || evict_fail || snoop_fail || (ctl_q.active && (op == OP_ABORT));
        do_commit  = ctl_q.active && (op == OP_END) && !do_abort;
        do_begin   = !ctl_q.active && (op == OP_BEGIN);

        ctl_d        = ctl_q;
        ctl_d.abort  = do_abort;
        ctl_d.commit = do_commit;
        ctl_d.hit    = upd_en && hit;
        if (do_begin) begin
            ctl_d.active  = 1'b1;
            ctl_d.safe_pc = cmd_pc;
        end
        if (do_abort || do_commit) ctl_d.active = 1'b0;
        if (do_abort)              ctl_d.redir  = ctl_q.safe_pc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign abort_o         = ctl_q.abort;
    assign commit_o        = ctl_q.commit;
    assign redirect_pc_o   = ctl_q.redir;
    assign hit_o           = ctl_q.hit;
    assign region_active_o = ctl_q.active;

    AST_ABORT_OVER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !(abort_o && commit_o)) else $error("abort and commit together"); // R14

    AST_ABORT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> !region_active_o) else $error("region open after abort"); // R4

    AST_COMMIT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> !region_active_o) else $error("region open after commit"); // R3

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !region_active_o |=> (!abort_o && !commit_o)) else $error("pulse without region"); // R12

    AST_PC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (region_active_o && $past(region_active_o)) |-> $stable(ctl_q.safe_pc)) else $error("safe PC moved"); // R2

endmodule

// File: tb/test_spec_alias_tracker.sv
`timescale 1ns/1ps
module test_spec_alias_tracker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cmd_op = '0;
    logic [31:0] cmd_addr = '0;
    logic [31:0] cmd_pc = '0;
    logic        snoop_valid = 1'b0;
    logic [31:0] snoop_addr = '0;
    logic        abort_o, commit_o, hit_o, region_active_o;
    logic [31:0] redirect_pc_o;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    spec_alias_tracker i_spec_alias_tracker (
        .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_pc(cmd_pc),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr), .abort_o(abort_o),
        .redirect_pc_o(redirect_pc_o), .commit_o(commit_o), .hit_o(hit_o),
        .region_active_o(region_active_o)
    );

    localparam logic [3:0] NOP = 0, BEG = 1, ENDR = 2, ABT = 3, LD = 4, LDM = 5, CLR = 6,
                           ST = 7, CR = 8, CW = 9, CRW = 10;
    localparam logic [31:0] TPC = 32'h0000_4000;

    // {req, op, addr, exp abort, exp commit, exp hit, exp active}
    localparam int NV = 22;
    localparam logic [47:0] TBL [NV] = '{
        {8'd13, LD,  32'h0000_1040, 4'b0000},  // R13 first access misses
        {8'd13, LD,  32'h0000_1040, 4'b0010},  // R13 second access hits
        {8'd2,  BEG, 32'h0000_0000, 4'b0001},  // R2
        {8'd5,  LDM, 32'h0000_2080, 4'b0001},  // R5 monitored load, miss
        {8'd8,  CW,  32'h0000_2080, 4'b0011},  // R8 W check, no written mark yet
        {8'd5,  CR,  32'h0000_1040, 4'b0011},  // R5 plain load set no monitor mark
        {8'd6,  CLR, 32'h0000_2080, 4'b0011},  // R6
        {8'd6,  CR,  32'h0000_2080, 4'b0011},  // R6 monitor mark gone
        {8'd8,  CW,  32'h0000_2080, 4'b1010},  // R8 written mark kept, abort
        {8'd2,  BEG, 32'h0000_0000, 4'b0001},  // R2
        {8'd9,  CRW, 32'h3000_00C0, 4'b0001},  // R9 miss, no abort
        {8'd9,  CW,  32'h3000_00C0, 4'b1010},  // R9 allocated with written mark
        {8'd2,  BEG, 32'h0000_0000, 4'b0001},  // R2
        {8'd5,  LD,  32'h3000_00C0, 4'b0011},  // R5 plain load in region
        {8'd5,  CR,  32'h3000_00C0, 4'b0011},  // R5 no monitor mark from plain load
        {8'd5,  LDM, 32'h0000_1040, 4'b0011},  // R5
        {8'd8,  CRW, 32'h0000_1040, 4'b1010},  // R8 RW sees monitor mark
        {8'd2,  BEG, 32'h0000_0000, 4'b0001},  // R2
        {8'd3,  ENDR,32'h0000_0000, 4'b0100},  // R3 commit
        {8'd12, ENDR,32'h0000_0000, 4'b0000},  // R12 end with no region
        {8'd12, ABT, 32'h0000_0000, 4'b0000},  // R12 abort with no region
        {8'd12, CW,  32'h0000_2080, 4'b0010}   // R12 checked store outside region
    };

    function automatic logic [31:0] mk(input int s, input int t);
        return (32'(t) << 12) | (32'(s) << 6);
    endfunction

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic cyc(input logic [3:0] op, input logic [31:0] addr, input logic [31:0] pc,
                       input logic sv, input logic [31:0] sa);
        @(negedge clk);
        cmd_op = op; cmd_addr = addr; cmd_pc = pc; snoop_valid = sv; snoop_addr = sa;
        @(posedge clk);
        #1;
    endtask

    task automatic c(input logic [3:0] op, input logic [31:0] addr);
        cyc(op, addr, TPC, 1'b0, '0);
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R1", "abort after reset", abort_o, 0);
        chk("R1", "commit after reset", commit_o, 0);
        chk("R1", "active after reset", region_active_o, 0);
        chk("R1", "hit after reset", hit_o, 0);

        for (int i = 0; i < NV; i++) begin
            string rq;
            rq = $sformatf("R%0d", TBL[i][47:40]);
            c(TBL[i][39:36], TBL[i][35:4]);
            chk(rq, $sformatf("row %0d abort", i), abort_o, TBL[i][3]);
            chk(rq, $sformatf("row %0d commit", i), commit_o, TBL[i][2]);
            chk(rq, $sformatf("row %0d hit", i), hit_o, TBL[i][1]);
            chk(rq, $sformatf("row %0d active", i), region_active_o, TBL[i][0]);
        end

        // R2 and R4: nested begin ignored, abort redirects to the first PC
        cyc(BEG, '0, 32'h0000_AAA0, 1'b0, '0);
        cyc(BEG, '0, 32'h0000_BBB0, 1'b0, '0);
        chk("R2", "active after nested begin", region_active_o, 1);
        c(ABT, '0);
        chk("R4", "explicit abort", abort_o, 1);
        chk("R4", "redirect PC", redirect_pc_o, 32'h0000_AAA0);
        chk("R4", "region closed", region_active_o, 0);
        c(NOP, '0);
        chk("R4", "abort is one cycle", abort_o, 0);

        // R3: marks cleared by end
        c(BEG, '0); c(LDM, mk(10, 1)); c(ENDR, '0);
        chk("R3", "commit pulse", commit_o, 1);
        c(NOP, '0);
        chk("R3", "commit is one cycle", commit_o, 0);
        c(BEG, '0); c(CR, mk(10, 1));
        chk("R3", "monitor mark cleared by end", abort_o, 0);
        chk("R3", "line still resident", hit_o, 1);
        c(ENDR, '0);

        // R4: marks cleared by abort
        c(BEG, '0); c(LDM, mk(11, 1)); c(ABT, '0);
        c(BEG, '0); c(CRW, mk(11, 1));
        chk("R4", "marks cleared by abort", abort_o, 0);
        c(ENDR, '0);

        // R12: monitored load and store outside a region leave no marks
        c(LDM, mk(12, 1)); c(ST, mk(12, 1));
        c(BEG, '0); c(CRW, mk(12, 1));
        chk("R12", "no marks from idle commands", abort_o, 0);
        c(ENDR, '0);

        // R7: plain store sets the written mark
        c(BEG, '0); c(ST, mk(44, 1)); c(CW, mk(44, 1));
        chk("R7", "plain store marks line", abort_o, 1);

        // R10: eviction of a marked line aborts, of an unmarked line does not
        cyc(BEG, '0, 32'h0000_E000, 1'b0, '0);
        c(LDM, mk(20, 1));
        for (int t = 2; t <= 8; t++) begin
            c(LD, mk(20, t));
            chk("R10", $sformatf("fill way tag %0d", t), abort_o, 0);
        end
        c(LD, mk(20, 9));
        chk("R10", "marked victim aborts", abort_o, 1);
        chk("R10", "redirect on overflow", redirect_pc_o, 32'h0000_E000);
        c(BEG, '0);
        for (int t = 1; t <= 9; t++) c(LD, mk(21, t));
        chk("R10", "unmarked victim no abort", abort_o, 0);
        chk("R10", "region still open", region_active_o, 1);
        c(ENDR, '0);

        // R13: LRU order and address split
        for (int t = 1; t <= 8; t++) c(LD, mk(30, t));
        chk("R13", "eighth fill misses", hit_o, 0);
        c(LD, mk(30, 1));
        chk("R13", "tag 1 resident", hit_o, 1);
        c(LD, mk(30, 9));
        chk("R13", "ninth tag misses", hit_o, 0);
        c(LD, mk(30, 1) | 32'h3F);
        chk("R13", "offset bits ignored", hit_o, 1);
        c(LD, mk(30, 2));
        chk("R13", "LRU tag 2 evicted", hit_o, 0);
        c(LD, mk(31, 1));
        chk("R13", "other set misses", hit_o, 0);

        // R11: snoops
        c(BEG, '0); c(ST, mk(40, 1)); c(LDM, mk(41, 1));
        cyc(NOP, '0, TPC, 1'b1, mk(41, 1));
        chk("R11", "snoop on monitor-only line", abort_o, 0);
        cyc(NOP, '0, TPC, 1'b1, mk(40, 2));
        chk("R11", "snoop miss", abort_o, 0);
        cyc(NOP, '0, TPC, 1'b1, mk(40, 1));
        chk("R11", "snoop on written line", abort_o, 1);

        // R14: end and snoop conflict in the same cycle
        cyc(BEG, '0, 32'h000C_0DE0, 1'b0, '0);
        c(ST, mk(42, 1));
        cyc(ENDR, '0, TPC, 1'b1, mk(42, 1));
        chk("R14", "abort wins", abort_o, 1);
        chk("R14", "no commit", commit_o, 0);
        chk("R14", "region closed", region_active_o, 0);
        chk("R14", "redirect", redirect_pc_o, 32'h000C_0DE0);
        c(BEG, '0); c(LDM, mk(43, 1));
        cyc(ENDR, '0, TPC, 1'b1, mk(43, 1));
        chk("R14", "clean commit with monitor-only snoop", commit_o, 1);
        chk("R14", "no abort with monitor-only snoop", abort_o, 0);

        c(NOP, '0);
        finish_run();
    end

endmodule